// File: doc/BRIEF.md
# Quadrature Transition Quality Detector

This block grades an FSK baseband signal by checking how regularly its one-bit limited I and Q channels rotate. A clean, demodulatable signal makes the I/Q pair step through its four states in a steady rotation. Noise shows up as reversals or as double steps. The detector counts a run of steps that keep the same rotation direction. Once per bit period it compares that run against a programmable threshold and updates a registered good/bad flag.

The raw I and Q bits pass through a two-flop synchronizer before any edge logic sees them. Software or a neighbouring block supplies a one-cycle bit-period tick and a 4-bit threshold. When deviation and bit rate are close, a clean signal gives about four steps per bit. Slower bit rates give more steps per bit, so the threshold should be raised to match. The flag only tells good from bad. It does no demodulation.

Top module: `qtq_detector`

## Requirements
- R1: While `rst_n` is low, and after release until the first bit tick, `quality_good` is 0. The synchronized I/Q pair is taken as 00 at reset, and no direction is recorded.
- R2: Each raw input passes two synchronizer flops. A step whose new level is first sampled at clock edge k is counted at edge k+2. A tick sampled at edge k+3 or later includes that step in its comparison.
- R3: The I/Q pair, written {I,Q}, is mapped to a phase: 00=0, 01=1, 11=2, 10=3. A one-bit change that raises the phase by one (mod 4) is a forward step. A one-bit change that lowers it by one is a backward step.
- R4: With no recorded direction (after reset or after a jump), a forward or backward step adds one to the run and records its direction.
- R5: A step in the recorded direction adds one to the run. A step against it sets the run to 0, and its own direction becomes the recorded one.
- R6: A cycle in which I and Q both change is a jump. A jump sets the run to 0 and clears the recorded direction.
- R7: On a cycle with `bit_tick` high, `quality_good` becomes 1 if the run is greater than or equal to `thresh` (unsigned), and 0 otherwise. A threshold of 0 always gives 1. The run then restarts.
- R8: The run saturates at 15. Further correct steps leave it at 15.
- R9: `quality_good` changes only on a tick cycle. Steps, jumps and reversals between ticks leave it unchanged.
- R10: A step counted in the same cycle as a tick is not part of that tick's comparison. A correct step there starts the new period at 1, and an incorrect one starts it at 0.
- R11: The recorded direction is kept across ticks, so the first step of a period is judged against the last step of the previous one.
- R12: Cycles with no change on the synchronized pair leave the run and the recorded direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_raw | input | 1 | Limited in-phase bit, asynchronous to `clk` |
| q_raw | input | 1 | Limited quadrature bit, asynchronous to `clk` |
| bit_tick | input | 1 | One-cycle pulse marking the end of a bit period |
| thresh | input | 4 | Minimum run length for a good verdict |
| quality_good | output | 1 | Registered quality verdict, updated on ticks |

## Verification
Every internal fault in this detector becomes visible only through the flag. A miscounted run, a stale direction or a lost jump appears at the port one cycle after the next tick, and only when it moves the run across the threshold. The bench therefore sets thresholds right at the edge of the expected run. It reports a verdict for every bit period, so a wrong state is caught within one period. Directed sequences target reversal across a tick boundary, jumps, saturation, and a step landing exactly on the tick. These cases let a wrong reset of the direction, a missing saturation or a slip of one cycle in latency flip a verdict.

// File: rtl/qtq_pkg.sv
package qtq_pkg;

  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_FWD  = 2'd1,
    REF_REV  = 2'd2
  } rot_ref_e;

  // Gray position of the {I,Q} pair on the rotation circle
  function automatic logic [1:0] iq_to_phase(input logic [1:0] iq);
    logic [1:0] ph;
    case (iq)
      2'b00:   ph = 2'd0;
      2'b01:   ph = 2'd1;
      2'b11:   ph = 2'd2;
      default: ph = 2'd3;
    endcase
    return ph;
  endfunction

endpackage

// File: rtl/qtq_rst_sync.sv
module qtq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/qtq_bit_sync.sv
module qtq_bit_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_async[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign d_sync[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/qtq_step_classify.sv
module qtq_step_classify
  import qtq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] iq_now,
  output logic       step_good,
  output logic       step_bad
);

  logic [1:0] prev_ph_q;
  logic [1:0] prev_ph_d;
  rot_ref_e   ref_q;
  rot_ref_e   ref_d;
  logic [1:0] cur_ph;
  logic [1:0] delta;
  logic       is_fwd;
  logic       is_rev;
  logic       is_jump;

  always_comb begin
    cur_ph  = iq_to_phase(iq_now);
    delta   = cur_ph - prev_ph_q;
    is_fwd  = (delta == 2'd1);
    is_rev  = (delta == 2'd3);
    is_jump = (delta == 2'd2);
  end

  always_comb begin
    step_good = (is_fwd && (ref_q != REF_REV)) ||
                (is_rev && (ref_q != REF_FWD));
    step_bad  = is_jump ||
                (is_fwd && (ref_q == REF_REV)) ||
                (is_rev && (ref_q == REF_FWD));
  end

  always_comb begin
    prev_ph_d = cur_ph;
    ref_d     = ref_q;
    if (is_fwd) begin
      ref_d = REF_FWD;
    end else if (is_rev) begin
      ref_d = REF_REV;
    end else if (is_jump) begin
      ref_d = REF_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ph_q <= 2'd0;
      ref_q     <= REF_NONE;
    end else begin
      prev_ph_q <= prev_ph_d;
      ref_q     <= ref_d;
    end
  end

endmodule

// File: rtl/qtq_run_counter.sv
module qtq_run_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_good,
  input  logic             step_bad,
  input  logic             bit_tick,
  output logic [CNT_W-1:0] run_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = bit_tick || step_good || step_bad;
    cnt_d  = cnt_q;
    if (bit_tick) begin
      cnt_d = step_good ? CNT_ONE : '0;
    end else if (step_bad) begin
      cnt_d = '0;
    end else if (step_good && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign run_cnt = cnt_q;

endmodule

// File: rtl/qtq_detector.sv
module qtq_detector #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_raw,
  input  logic             q_raw,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] thresh,
  output logic             quality_good
);

  logic             rst_sync_n;
  logic [1:0]       iq_sync;
  logic             step_good;
  logic             step_bad;
  logic [CNT_W-1:0] run_cnt;
  logic             flag_q;
  logic             flag_d;

  qtq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qtq_bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_iq_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async ({i_raw, q_raw}),
    .d_sync  (iq_sync)
  );

  qtq_step_classify u_classify (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .iq_now    (iq_sync),
    .step_good (step_good),
    .step_bad  (step_bad)
  );

  qtq_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_good (step_good),
    .step_bad  (step_bad),
    .bit_tick  (bit_tick),
    .run_cnt   (run_cnt)
  );

  always_comb begin
    flag_d = (run_cnt >= thresh);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
    end else if (bit_tick) begin
      flag_q <= flag_d;
    end
  end

  assign quality_good = flag_q;

endmodule

// File: rtl/qtq_detector_chk.sv
module qtq_detector_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bit_tick,
  input logic [CNT_W-1:0] thresh,
  input logic             quality_good,
  input logic [1:0]       iq_sync,
  input logic             step_good,
  input logic             step_bad,
  input logic [CNT_W-1:0] run_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always @(negedge clk) begin
    if (rst_sync_n === 1'b0) begin
      AST_RESET_LOW: assert (quality_good == 1'b0) else $error("flag high in reset"); // R1
    end
  end

  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({step_good, step_bad})) else $error("step both good and bad"); // R5

  AST_JUMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((iq_sync == ~$past(iq_sync)) && !bit_tick) |=> (run_cnt == '0))
    else $error("jump kept run"); // R6

  AST_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_tick && (thresh == '0)) |=> quality_good)
    else $error("zero threshold gave bad"); // R7

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((run_cnt == CNT_MAX) && !bit_tick && !step_bad) |=> (run_cnt == CNT_MAX))
    else $error("saturated run moved"); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bit_tick |=> $stable(quality_good))
    else $error("flag moved without tick"); // R9

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_tick |=> (run_cnt <= CNT_W'(1)))
    else $error("run not restarted at tick"); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((iq_sync == $past(iq_sync)) && !bit_tick) |=> $stable(run_cnt))
    else $error("run moved while idle"); // R12

endmodule

bind qtq_detector qtq_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .bit_tick     (bit_tick),
  .thresh       (thresh),
  .quality_good (quality_good),
  .iq_sync      (iq_sync),
  .step_good    (step_good),
  .step_bad     (step_bad),
  .run_cnt      (run_cnt)
);

// File: tb/qtq_detector_tb.sv
module qtq_detector_tb;

  localparam int CNT_W = 4;
  localparam int CMAX  = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             i_raw;
  logic             q_raw;
  logic             bit_tick;
  logic [CNT_W-1:0] thresh;
  logic             quality_good;

  always #4 clk = ~clk;

  qtq_detector u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_raw        (i_raw),
    .q_raw        (q_raw),
    .bit_tick     (bit_tick),
    .thresh       (thresh),
    .quality_good (quality_good)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  bit    exp_q[$];
  bit    last_exp = 1'b0;
  string cur_req  = "R1";

  // reference model state
  int m_ph  = 0;
  int m_ref = 0; // 0 none, 1 forward, 2 backward
  int m_cnt = 0;

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] iq_of(input int p);
    case (p & 3)
      0:       return 2'b00;
      1:       return 2'b01;
      2:       return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic void model_step(input int np);
    int d;
    d = (np - m_ph) & 3;
    if (d == 2) begin
      m_cnt = 0;
      m_ref = 0;
    end else if (d == 1 || d == 3) begin
      int dir;
      dir = (d == 1) ? 1 : 2;
      if (m_ref != 0 && m_ref != dir) m_cnt = 0;
      else if (m_cnt < CMAX) m_cnt++;
      m_ref = dir;
    end
    m_ph = np & 3;
  endfunction

  task automatic step(input int p);
    @(negedge clk);
    {i_raw, q_raw} = iq_of(p);
    model_step(p);
    repeat (3) @(negedge clk);
  endtask

  task automatic fwd(input int n);
    for (int k = 0; k < n; k++) step(m_ph + 1);
  endtask

  task automatic rev(input int n);
    for (int k = 0; k < n; k++) step(m_ph + 3);
  endtask

  task automatic jump();
    step(m_ph + 2);
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    exp_q.push_back(m_cnt >= int'(thresh));
    m_cnt = 0;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // step whose synchronized edge lands lag-2 cycles before the tick edge
  task automatic step_tick(input int p, input int lag);
    @(negedge clk);
    {i_raw, q_raw} = iq_of(p);
    if (lag >= 3) model_step(p);
    repeat (lag) @(negedge clk);
    bit_tick = 1'b1;
    exp_q.push_back(m_cnt >= int'(thresh));
    m_cnt = 0;
    if (lag < 3) model_step(p);
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // monitor: pop one verdict per tick
  initial begin
    forever begin
      @(posedge clk);
      if (bit_tick === 1'b1 && rst_n === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_tests++;
          n_fail++;
          $display("FAIL R7 %s: actual verdict with empty queue expected none", cur_req);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check({"R7 ", cur_req}, quality_good, e);
          last_exp = e;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    i_raw    = 1'b0;
    q_raw    = 1'b0;
    bit_tick = 1'b0;
    thresh   = '0;
    repeat (4) @(negedge clk);
    check("R1 in reset", quality_good, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", quality_good, 1'b0);

    // R3/R4: forward rotation, threshold met exactly
    cur_req = "R3 fwd4"; thresh = 4'd4; fwd(4); tick();
    cur_req = "R3 fwd3"; thresh = 4'd4; fwd(3); tick();
    // R11/R5: first backward step reverses the forward reference of last period
    cur_req = "R11 R5 rev5"; thresh = 4'd5; rev(5); tick();
    cur_req = "R11 rev5 kept"; thresh = 4'd5; rev(5); tick();
    // R5: reversal mid-period
    cur_req = "R5 mid reverse"; thresh = 4'd3; fwd(1); rev(3); tick();
    cur_req = "R5 reverse low"; thresh = 4'd4; rev(2); fwd(3); tick();
    // R6/R4: jump clears run and direction
    cur_req = "R6 jump"; thresh = 4'd2; fwd(2); jump(); fwd(1); tick();
    cur_req = "R4 after jump"; thresh = 4'd3; jump(); rev(3); tick();
    // R8: saturation
    cur_req = "R8 sat"; thresh = 4'd15; rev(20); tick();
    cur_req = "R8 under"; thresh = 4'd15; rev(14); tick();
    // R7: threshold zero and idle period (R12)
    cur_req = "R7 thr0"; thresh = 4'd0; tick();
    cur_req = "R12 idle"; thresh = 4'd1; repeat (10) @(negedge clk); tick();
    // R2/R10: latency at the tick
    cur_req = "R2 lag3"; thresh = 4'd1; step_tick(m_ph + 3, 3);
    cur_req = "R10 lag2"; thresh = 4'd1; step_tick(m_ph + 3, 2);
    cur_req = "R10 carry"; thresh = 4'd1; tick();
    cur_req = "R10 bad on tick"; thresh = 4'd1; step_tick(m_ph + 1, 2);
    cur_req = "R10 bad carry"; thresh = 4'd1; tick();

    // R9: verdict holds while steps, jumps and reversals arrive
    cur_req = "R9 set good"; thresh = 4'd2; fwd(3); tick();
    fwd(1);
    check("R9 hold after step", quality_good, last_exp);
    jump();
    check("R9 hold after jump", quality_good, last_exp);
    rev(1); fwd(1);
    check("R9 hold after reversal", quality_good, last_exp);
    cur_req = "R9 set bad"; thresh = 4'd9; tick();
    fwd(6);
    check("R9 hold bad", quality_good, last_exp);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7: actual %0d pending verdicts expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule